// File: doc/BRIEF.md
# MII/GMII Transmit Front-End with Collision Abort

This block sits between a MAC transmit engine and an Ethernet PHY. It takes a byte stream with a ready/valid handshake and drives the PHY-side transmit data, enable and error lines, all registered on the transmit clock. It has two width modes. In 4-bit mode (`gmii_mode` = 0) each byte leaves as two nibbles. In 8-bit mode (`gmii_mode` = 1) each byte leaves in a single beat. An error flag from upstream turns on the PHY error line, and the line stays on until the frame ends.

In half-duplex operation a collision reported by the PHY while a frame is on the wire cuts the frame off at once. The block then discards the rest of that frame from upstream and holds off for a random number of slot times. The random count comes from a 16-bit LFSR. The range of the count widens with each further collision of the same frame. On the sixteenth collision the frame is given up and a pulse is raised. A carrier/activity LED output is stretched so that short bursts remain visible.

Controller states and transitions:
- `ST_IDLE` goes to `ST_LEAD` when a byte is accepted.
- `ST_LEAD` (a full byte, or the low nibble) goes to `ST_TRAIL` in 4-bit mode. In 8-bit mode it goes back to `ST_LEAD` when the next byte is accepted, and to `ST_IDLE` at the end of the frame or on underrun.
- `ST_TRAIL` (the high nibble) goes to `ST_LEAD` when the next byte is accepted, or to `ST_IDLE`.
- `ST_LEAD` and `ST_TRAIL` go to `ST_DRAIN` on a collision while bytes of the frame are still pending upstream. They go straight to `ST_HOLDOFF` when no bytes are pending, or straight to `ST_IDLE` when the frame is given up.
- `ST_DRAIN` goes to `ST_HOLDOFF` once the final byte is swallowed, or to `ST_IDLE` if the frame was given up.
- `ST_HOLDOFF` goes to `ST_IDLE` when the slot wait is over.

Top module: `xmii_tx_frontend`

## Requirements
- R1: `phy_txen` is high exactly in the cycles that carry frame data. It rises the cycle after the first byte is accepted and falls the cycle after the final beat. Two frames always have at least one low cycle between them.
- R2: With `gmii_mode`=0, each byte takes two beats. The low nibble goes first and the high nibble second, both on `phy_txd[3:0]`, with `phy_txd[7:4]`=0. `in_ready` is low during the low-nibble beat.
- R3: With `gmii_mode`=1, each byte takes one beat on `phy_txd[7:0]`. `in_ready` stays high during the beats until the final byte has been accepted.
- R4: `phy_txer` goes high on the beat(s) of the byte accepted with `in_err`=1. It stays high on every later beat of that frame and is low when `phy_txen` is low.
- R5: With `half_duplex`=1, `col` sampled high while `phy_txen` is high makes `phy_txen` and `phy_txer` low from the next cycle. The remaining bytes of that frame, up to and including `in_last`, are accepted and put nothing on the PHY lines.
- R6: With `half_duplex`=0, `col` has no effect on the output beats or on `tx_abandon`.
- R7: After the n-th collision of a frame (n<16), `in_ready` stays low for r*SLOT_CYCLES+1 cycles once the frame has been drained. Here r is drawn from 0..2^min(n,10)-1. The count n restarts at 0 when a frame completes.
- R8: The 16th collision of a frame raises `tx_abandon` for one cycle, skips the hold-off, and restarts the collision count.
- R9: `led_act` is high from the cycle after `crs` or `phy_txen` is sampled high, and stays high for LED_HOLD cycles after the last such sample.
- R10: During and just after reset, `phy_txen`, `phy_txer`, `phy_txd`, `tx_abandon` and `led_act` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gmii_mode | input | 1 | 1: byte-wide beats, 0: nibble beats |
| half_duplex | input | 1 | 1: collisions are honoured |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_err | input | 1 | Upstream marks this byte bad |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Block takes the byte at this edge |
| col | input | 1 | Collision from the PHY |
| crs | input | 1 | Carrier sense from the PHY |
| phy_txd | output | 8 | Transmit data toward the PHY |
| phy_txen | output | 1 | Transmit enable |
| phy_txer | output | 1 | Transmit error |
| tx_abandon | output | 1 | One-cycle pulse when a frame is given up |
| led_act | output | 1 | Stretched traffic indicator |

## Verification
Two functions can land in the same cycle: the sticky error and the collision abort. The bench sends a frame whose second byte carries `in_err`, and raises `col` in the beat where that byte is on the wire. It first confirms that `phy_txer` is high in that beat. It then confirms that on the next beat both `phy_txen` and `phy_txer` are low, so the abort wins over the error and no error beat outlives the enable. The hold-off that follows is then measured against the widened range for a second collision.

// File: rtl/xtx_pkg.sv
package xtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_DRAIN,
        ST_HOLDOFF
    } xtx_state_e;

endpackage

// File: rtl/xtx_lfsr.sv
module xtx_lfsr #(
    parameter int          W     = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] lfsr_q;

    // Galois form, advances every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED[W-1:0];
        end else begin
            lfsr_q <= {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? TAPS[W-1:0] : '0);
        end
    end

    assign value = lfsr_q;

    a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/xtx_backoff.sv
module xtx_backoff #(
    parameter int SLOT_CYCLES = 512,
    parameter int SLOTS_W     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SLOTS_W-1:0] load_slots,
    input  logic               run,
    output logic               done
);

    localparam int            CW       = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] CYC_LAST = CW'(SLOT_CYCLES - 1);

    logic [SLOTS_W-1:0] slots_q;
    logic [CW-1:0]      cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_q <= '0;
            cyc_q   <= '0;
        end else if (load) begin
            slots_q <= load_slots;
            cyc_q   <= CYC_LAST;
        end else if (run && (slots_q != '0)) begin
            if (cyc_q == '0) begin
                slots_q <= slots_q - 1'b1;
                cyc_q   <= CYC_LAST;
            end else begin
                cyc_q <= cyc_q - 1'b1;
            end
        end
    end

    assign done = (slots_q == '0);

    // once expired, the wait stays expired until a new draw
    a_r7_wait_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/xtx_led_stretch.sv
module xtx_led_stretch #(
    parameter int HOLD = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic led
);

    localparam int            CW   = $clog2(HOLD + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (activity) begin
            cnt_q <= FULL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign led = (cnt_q != '0);

    a_r9_led_lights: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> led);

endmodule

// File: rtl/xmii_tx_frontend.sv
module xmii_tx_frontend
    import xtx_pkg::*;
#(
    parameter int SLOT_CYCLES  = 512,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10,
    parameter int LED_HOLD     = 6_250_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gmii_mode,
    input  logic       half_duplex,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_err,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       col,
    input  logic       crs,
    output logic [7:0] phy_txd,
    output logic       phy_txen,
    output logic       phy_txer,
    output logic       tx_abandon,
    output logic       led_act
);

    localparam int LFSR_W  = 16;
    localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
    localparam int SLOTS_W = BACKOFF_CAP;

    xtx_state_e state_q, state_d;

    logic [3:0]         upper_q;
    logic               last_q;
    logic               err_q;
    logic               drop_q;
    logic [ATT_W-1:0]   coll_q;
    logic [ATT_W-1:0]   coll_next;
    logic               accept;
    logic               on_wire;
    logic               col_hit;
    logic               give_up;
    logic               skip_drain;
    logic               load_beat;
    logic               show_upper;
    logic               close_frame;
    logic               beat_err;
    logic [LFSR_W-1:0]  rnd;
    logic [SLOTS_W-1:0] range_mask;
    logic [SLOTS_W-1:0] draw;
    logic               bo_done;

    // ---------------- handshake ----------------
    always_comb begin
        unique case (state_q)
            ST_IDLE:    in_ready = 1'b1;
            ST_LEAD:    in_ready = gmii_mode && !last_q;
            ST_TRAIL:   in_ready = !last_q;
            ST_DRAIN:   in_ready = 1'b1;
            ST_HOLDOFF: in_ready = 1'b0;
            default:    in_ready = 1'b0;
        endcase
    end

    assign accept     = in_valid && in_ready;
    assign on_wire    = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
    assign col_hit    = half_duplex && col && on_wire;
    assign coll_next  = coll_q + 1'b1;
    assign give_up    = col_hit && (coll_next == ATT_W'(MAX_ATTEMPTS));
    assign skip_drain = last_q || (accept && in_last);

    assign load_beat   = accept && !col_hit &&
                         ((state_q == ST_IDLE) || on_wire);
    assign show_upper  = !col_hit && (state_q == ST_LEAD) && !gmii_mode;
    assign close_frame = !col_hit && on_wire && !load_beat && !show_upper;
    assign beat_err    = ((state_q == ST_IDLE) ? 1'b0 : err_q) | in_err;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_LEAD;
            end
            ST_LEAD, ST_TRAIL: begin
                if (col_hit) begin
                    if (!skip_drain)  state_d = ST_DRAIN;
                    else if (give_up) state_d = ST_IDLE;
                    else              state_d = ST_HOLDOFF;
                end else if (show_upper) begin
                    state_d = ST_TRAIL;
                end else if (load_beat) begin
                    state_d = ST_LEAD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (accept && in_last) state_d = drop_q ? ST_IDLE : ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (bo_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- registered outputs and frame context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_txd    <= '0;
            phy_txen   <= 1'b0;
            phy_txer   <= 1'b0;
            tx_abandon <= 1'b0;
            upper_q    <= '0;
            last_q     <= 1'b0;
            err_q      <= 1'b0;
            drop_q     <= 1'b0;
            coll_q     <= '0;
        end else begin
            tx_abandon <= 1'b0;
            if (col_hit) begin
                phy_txd    <= '0;
                phy_txen   <= 1'b0;
                phy_txer   <= 1'b0;
                err_q      <= 1'b0;
                last_q     <= 1'b0;
                drop_q     <= give_up;
                tx_abandon <= give_up;
                coll_q     <= give_up ? '0 : coll_next;
            end else if (load_beat) begin
                phy_txd  <= gmii_mode ? in_data : {4'h0, in_data[3:0]};
                phy_txen <= 1'b1;
                phy_txer <= beat_err;
                err_q    <= beat_err;
                upper_q  <= in_data[7:4];
                last_q   <= in_last;
            end else if (show_upper) begin
                phy_txd  <= {4'h0, upper_q};
                phy_txer <= err_q;
            end else if (close_frame) begin
                phy_txd  <= '0;
                phy_txen <= 1'b0;
                phy_txer <= 1'b0;
                err_q    <= 1'b0;
                last_q   <= 1'b0;
                if (last_q) coll_q <= '0;
            end
        end
    end

    // ---------------- backoff draw ----------------
    always_comb begin
        for (int i = 0; i < SLOTS_W; i++) begin
            range_mask[i] = (i < ((int'(coll_next) > BACKOFF_CAP) ? BACKOFF_CAP
                                                                  : int'(coll_next)));
        end
    end

    assign draw = rnd[SLOTS_W-1:0] & range_mask;

    xtx_lfsr #(
        .W (LFSR_W)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    xtx_backoff #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .SLOTS_W     (SLOTS_W)
    ) u_backoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (col_hit && !give_up),
        .load_slots (draw),
        .run        (state_q == ST_HOLDOFF),
        .done       (bo_done)
    );

    xtx_led_stretch #(
        .HOLD (LED_HOLD)
    ) u_led (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (crs || phy_txen),
        .led      (led_act)
    );

    // ---------------- assertions ----------------
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_txen && phy_txer) |=> (!phy_txen || phy_txer));

    a_r4_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
        phy_txer |-> phy_txen);

    a_r5_col_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duplex && col && phy_txen) |=> !phy_txen);

    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_txen && !$past(gmii_mode)) |-> (phy_txd[7:4] == 4'h0));

    a_r8_abandon_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abandon |=> !tx_abandon);

    a_r6_fd_no_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abandon |-> $past(half_duplex));

endmodule

// File: tb/xmii_tx_frontend_test.sv
module xmii_tx_frontend_test;

    localparam int SLOT = 4;
    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gmii_mode = 1'b1;
    logic       half_duplex = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_err = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       col = 1'b0;
    logic       crs = 1'b0;
    logic [7:0] phy_txd;
    logic       phy_txen;
    logic       phy_txer;
    logic       tx_abandon;
    logic       led_act;

    always #4 clk = ~clk;

    xmii_tx_frontend #(
        .SLOT_CYCLES  (SLOT),
        .MAX_ATTEMPTS (16),
        .BACKOFF_CAP  (10),
        .LED_HOLD     (HOLD)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gmii_mode   (gmii_mode),
        .half_duplex (half_duplex),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_err      (in_err),
        .in_last     (in_last),
        .in_ready    (in_ready),
        .col         (col),
        .crs         (crs),
        .phy_txd     (phy_txd),
        .phy_txen    (phy_txen),
        .phy_txer    (phy_txer),
        .tx_abandon  (tx_abandon),
        .led_act     (led_act)
    );

    int         n_checks = 0;
    int         n_fail = 0;
    logic [8:0] exp_q[$];
    logic [8:0] mon_e;
    bit         sb_on = 1'b0;
    bit         quiet = 1'b0;
    string      sb_tag = "R1";
    int         abandon_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected beats as the block puts them on the wire
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_abandon) abandon_seen++;
            if (phy_txen) begin
                if (quiet) begin
                    chk(1'b0, "R5", "beat while draining or holding off", 1, 0);
                end else if (sb_on) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, sb_tag, "unexpected beat", int'(phy_txd), 0);
                    end else begin
                        mon_e = exp_q.pop_front();
                        chk({phy_txd, phy_txer} == mon_e, sb_tag, "beat {txd,txer}",
                            int'({phy_txd, phy_txer}), int'(mon_e));
                    end
                end
            end
        end
    end

    // driver: offers bytes, pushes the beats they must produce
    task automatic send_frame(input int n, input logic [7:0] base,
                              input int err_at, input bit push);
        bit         sticky;
        logic [7:0] b;
        sticky = 1'b0;
        for (int i = 0; i < n; i++) begin
            b = base ^ 8'(i * 37);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = b;
            in_last  = (i == n - 1);
            in_err   = (i == err_at);
            while (!in_ready) @(negedge clk);
            if (i == err_at) sticky = 1'b1;
            if (push) begin
                if (gmii_mode) begin
                    exp_q.push_back({b, sticky});
                end else begin
                    exp_q.push_back({4'h0, b[3:0], sticky});
                    exp_q.push_back({4'h0, b[7:4], sticky});
                end
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_err   = 1'b0;
    endtask

    task automatic frame_closed(input string req);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, "all beats delivered", exp_q.size(), 0);
        chk(phy_txen == 1'b0, req, "txen low after frame", int'(phy_txen), 0);
    endtask

    task automatic collide(input int wait_beats, input bit want_err);
        @(negedge clk);
        while (!phy_txen) @(negedge clk);
        repeat (wait_beats) @(negedge clk);
        if (want_err) chk(phy_txer == 1'b1, "R4", "txer on flagged beat", int'(phy_txer), 1);
        col = 1'b1;
        @(negedge clk);
        col = 1'b0;
        chk({phy_txen, phy_txer} == 2'b00, "R5", "txen/txer after collision",
            int'({phy_txen, phy_txer}), 0);
        quiet = 1'b1;
    endtask

    task automatic measure(input int k, input bit expect_none);
        int c;
        int lim;
        c = 0;
        lim = ((1 << k) - 1) * SLOT + 1;
        while (!in_ready && c < 20000) begin
            c++;
            @(negedge clk);
        end
        if (expect_none) begin
            chk(c == 0, "R8", "no hold-off after giving up", c, 0);
        end else begin
            chk(c >= 1 && c <= lim, "R7", "hold-off length within range", c, lim);
            chk(((c - 1) % SLOT) == 0, "R7", "hold-off in whole slots", (c - 1) % SLOT, 0);
        end
        quiet = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk({phy_txen, phy_txer, tx_abandon, led_act} == 4'b0, "R10", "flags in reset",
            int'({phy_txen, phy_txer, tx_abandon, led_act}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phy_txd == 8'h00, "R10", "txd after reset", int'(phy_txd), 0);
        chk(in_ready == 1'b1, "R10", "ready after reset", int'(in_ready), 1);

        // R3 byte mode, clean frame
        sb_on = 1'b1; sb_tag = "R3";
        fork
            send_frame(5, 8'h3C, -1, 1'b1);
            begin
                @(negedge clk);
                while (!phy_txen) @(negedge clk);
                chk(in_ready == 1'b1, "R3", "ready during byte beat", int'(in_ready), 1);
            end
        join
        frame_closed("R1");

        // R4 byte mode, error from third byte on
        sb_tag = "R4";
        send_frame(6, 8'hA5, 2, 1'b1);
        frame_closed("R4");

        // R2 nibble mode
        gmii_mode = 1'b0; sb_tag = "R2";
        fork
            send_frame(4, 8'h96, -1, 1'b1);
            begin
                @(negedge clk);
                while (!phy_txen) @(negedge clk);
                chk(in_ready == 1'b0, "R2", "ready low on low-nibble beat", int'(in_ready), 0);
            end
        join
        frame_closed("R2");

        // R4 nibble mode with error
        sb_tag = "R4";
        send_frame(3, 8'h5A, 1, 1'b1);
        frame_closed("R4");

        // R6 full duplex: collisions change nothing
        gmii_mode = 1'b1; sb_tag = "R6";
        fork
            send_frame(6, 8'h11, -1, 1'b1);
            begin
                @(negedge clk);
                while (!phy_txen) @(negedge clk);
                col = 1'b1;
                repeat (2) @(negedge clk);
                col = 1'b0;
            end
        join
        frame_closed("R6");
        chk(abandon_seen == 0, "R6", "no give-up pulse", abandon_seen, 0);

        // R5 / R7 first collision, nibble mode
        sb_on = 1'b0; exp_q.delete();
        half_duplex = 1'b1; gmii_mode = 1'b0;
        fork
            send_frame(5, 8'h77, -1, 1'b0);
            collide(2, 1'b0);
        join
        measure(1, 1'b0);

        // R4 + R5 same beat, second collision of the same frame
        gmii_mode = 1'b1;
        fork
            send_frame(4, 8'hC3, 1, 1'b0);
            collide(1, 1'b1);
        join
        measure(2, 1'b0);

        // clean frame restarts the collision count (R1)
        sb_on = 1'b1; sb_tag = "R1";
        send_frame(3, 8'h42, -1, 1'b1);
        frame_closed("R1");
        sb_on = 1'b0;

        // R7 / R8 sixteen collisions of one frame
        for (int a = 1; a <= 16; a++) begin
            fork
                send_frame(4, 8'h20, -1, 1'b0);
                collide(0, 1'b0);
            join
            if (a < 16) begin
                measure((a > 10) ? 10 : a, 1'b0);
            end else begin
                measure(0, 1'b1);
            end
            if (a == 15) chk(abandon_seen == 0, "R8", "no pulse before 16th", abandon_seen, 0);
        end
        chk(abandon_seen == 1, "R8", "one give-up pulse", abandon_seen, 1);

        // R8 count restarted: next collision draws from the first range
        fork
            send_frame(3, 8'h0F, -1, 1'b0);
            collide(0, 1'b0);
        join
        measure(1, 1'b0);

        // R9 LED stretch
        half_duplex = 1'b0;
        repeat (HOLD + 4) @(negedge clk);
        chk(led_act == 1'b0, "R9", "led idle", int'(led_act), 0);
        crs = 1'b1;
        @(negedge clk);
        crs = 1'b0;
        chk(led_act == 1'b1, "R9", "led on after carrier", int'(led_act), 1);
        repeat (HOLD - 1) @(negedge clk);
        chk(led_act == 1'b1, "R9", "led held", int'(led_act), 1);
        @(negedge clk);
        chk(led_act == 1'b0, "R9", "led released", int'(led_act), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule